// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column addresses of one memory burst inside an open row. A one-cycle start pulse captures an 8-bit starting column, a 3-bit burst length code and an ordering select. From the following clock on, the block presents one column address per cycle on `col_o` and holds `valid_o` high while it does so.

Two orderings are supported. In the sequential ordering, the low bits count upward and wrap inside the aligned block that holds the starting column. In the interleave ordering, the low bits are the starting column XOR the beat index. The column bits above the burst field do not change during a burst.

The page length walks all 256 columns of the row over and over. It ends only when it is stopped or restarted. Any burst can be cut short by a stop input. A fresh start pulse replaces the burst in progress from the next cycle on. The block does not handle data, masking or read latency alignment.

Top module: `burst_col_gen`

## Requirements
- R1: While no burst is active, `valid_o` is 0 and `col_o` reads 0. This includes the state right after reset.
- R2: In the cycle after a clock edge that samples `start_i` high, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`.
- R3: The length code sets the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 selects the page length. After the last beat of a fixed-length burst, `valid_o` is 0 in the next cycle.
- R4: With `ilv_i`=0, beat n of a burst of length L carries low bits ((start mod L) + n) mod L.
- R5: With `ilv_i`=1 and L ≤ 8, beat n carries low bits (start mod L) XOR n.
- R6: Column bits above the low log2(L) bits stay at their starting values on every beat.
- R7: A page-length burst increments the whole column by one per beat, modulo 256. It keeps going past 256 beats until it is stopped or restarted.
- R8: A page-length request with `ilv_i`=1 behaves exactly like a sequential page-length burst.
- R9: When `stop_i` is high at an edge during a burst with no start, `valid_o` is 0 from the next cycle. This holds at any length. When `stop_i` is high while idle, it has no effect.
- R10: A start pulse during a burst restarts the block from the new parameters in the next cycle. When start and stop come together, the start wins.
- R11: The reserved length codes 4, 5 and 6 give a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load a new burst |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects the interleave ordering |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | Column address is valid |

## Verification
The assertions take for granted that inputs are known (0 or 1) at every sampled edge, and that `start_col_i`, `len_code_i` and `ilv_i` matter only in a cycle that carries a start. The stimulus changes inputs only on the falling clock edge. It drives defined values from time zero and holds stop and start low during reset. Random traffic mixes every length code, including the reserved ones, with both orderings. It stops or restarts page bursts at random beats, and it pulses stop while idle to check that nothing leaves the idle state.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int LEN_W   = 3,
    parameter int MAX_LOG = 3
) (
    input  logic [LEN_W-1:0] len_code,
    input  logic             ilv_req,
    output logic [COL_W-1:0] mask,
    output logic             full,
    output logic             ilv_eff
);
    always_comb begin
        full    = (len_code == LEN_W'(BLEN_PAGE));
        mask    = '0;
        if (full) begin
            mask = '1;
        end else if (int'(len_code) <= MAX_LOG) begin
            for (int i = 0; i < COL_W; i++) begin
                mask[i] = (i < int'(len_code));
            end
        end
        // page length has no interleave form: fall back to sequential
        ilv_eff = ilv_req & ~full;
    end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] off;

    always_comb begin
        off = ilv ? (base ^ cnt) : (base + cnt);
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = mask[b] ? off[b] : base[b];
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int LEN_W   = 3,
    parameter int MAX_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] len_code_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o
);
    typedef struct packed {
        logic             active;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
    } gen_state_t;

    gen_state_t       st_d, st_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_ilv;
    logic [COL_W-1:0] calc_col;

    burst_len_decode #(
        .COL_W  (COL_W),
        .LEN_W  (LEN_W),
        .MAX_LOG(MAX_LOG)
    ) len_dec_i (
        .len_code(len_code_i),
        .ilv_req (ilv_i),
        .mask    (dec_mask),
        .full    (dec_full),
        .ilv_eff (dec_ilv)
    );

    burst_addr_calc #(
        .COL_W(COL_W)
    ) addr_calc_i (
        .base(st_q.base),
        .cnt (st_q.cnt),
        .mask(st_q.mask),
        .ilv (st_q.ilv),
        .col (calc_col)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.full   = dec_full;
            st_d.ilv    = dec_ilv;
            st_d.base   = start_col_i;
            st_d.cnt    = '0;
            st_d.mask   = dec_mask;
        end else if (st_q.active) begin
            if (stop_i) begin
                st_d.active = 1'b0;
            end else if (!st_q.full && (st_q.cnt == st_q.mask)) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.active;
    assign col_o   = st_q.active ? calc_col : '0;

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (col_o == '0));

    p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    p_last_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !st_q.full && !start_i && !stop_i && st_q.cnt == st_q.mask)
        |=> !valid_o);

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i))
        |-> ((col_o & ~st_q.mask) == ($past(col_o) & ~st_q.mask)));

    p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.full && !start_i && !stop_i)
        |=> (valid_o && col_o == $past(col_o) + 1'b1));

    p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .start_col_i(start_col_i),
        .len_code_i (len_code_i),
        .ilv_i      (ilv_i),
        .stop_i     (stop_i),
        .col_o      (col_o),
        .valid_o    (valid_o)
    );

    function automatic int exp_len(input logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] c, input logic [2:0] code,
                                           input logic ilv, input int n);
        int len = exp_len(code);
        int lo  = int'(c) % len;
        int low;
        if (len == 256) return 8'((int'(c) + n) % 256);
        if (ilv) low = lo ^ n;
        else     low = (lo + n) % len;
        return 8'(int'(c) - lo + low);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic issue(input logic [7:0] c, input logic [2:0] code, input logic ilv);
        start_i     = 1'b1;
        start_col_i = c;
        len_code_i  = code;
        ilv_i       = ilv;
    endtask

    // Called after a start was set on a falling edge. kind 0: run out, 1: stop at beat cut,
    // 2: restart at beat cut with the n* parameters (also asserting stop when nstop).
    task automatic follow(input logic [7:0] c, input logic [2:0] code, input logic ilv,
                          input string tag, input int kind, input int cut,
                          input logic [7:0] nc, input logic [2:0] ncode, input logic nilv,
                          input bit nstop);
        int len = exp_len(code);
        for (int n = 0; ; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            stop_i  = 1'b0;
            check(valid_o === 1'b1, {tag, " valid"}, int'(valid_o), 1);
            check(col_o === exp_col(c, code, ilv, n), {tag, " col"}, int'(col_o),
                  int'(exp_col(c, code, ilv, n)));
            if (kind == 1 && n == cut) begin
                stop_i = 1'b1;
                break;
            end
            if (kind == 2 && n == cut) begin
                issue(nc, ncode, nilv);
                stop_i = nstop;
                return;
            end
            if (kind == 0 && n == len - 1) break;
        end
        @(negedge clk);
        stop_i = 1'b0;
        check(valid_o === 1'b0, {tag, " end R3/R9"}, int'(valid_o), 0);
        check(col_o === 8'd0, {tag, " idle R1"}, int'(col_o), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rc, pc;
        logic [2:0] rcode, pcode;
        logic       ril, pil;
        bit         pending;
        int         kind, cut;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(valid_o === 1'b0 && col_o === 8'd0, "R1 reset", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o === 1'b0, "R1 after reset", int'(valid_o), 0);

        // R4: sequential length 4 from 1 -> 1 2 3 0
        @(negedge clk); issue(8'd1, 3'd2, 1'b0);
        follow(8'd1, 3'd2, 1'b0, "R4 seq4", 0, 0, 0, 0, 0, 0);
        // R5: interleave length 8 from 5 -> 5 4 7 6 1 0 3 2
        @(negedge clk); issue(8'd5, 3'd3, 1'b1);
        follow(8'd5, 3'd3, 1'b1, "R5 ilv8", 0, 0, 0, 0, 0, 0);
        // R6: upper bits kept, sequential 8 from 0xD5
        @(negedge clk); issue(8'hD5, 3'd3, 1'b0);
        follow(8'hD5, 3'd3, 1'b0, "R6 seq8 upper", 0, 0, 0, 0, 0, 0);
        // R3 / R2: length 1 and 2
        @(negedge clk); issue(8'h7F, 3'd0, 1'b1);
        follow(8'h7F, 3'd0, 1'b1, "R3 len1", 0, 0, 0, 0, 0, 0);
        @(negedge clk); issue(8'h33, 3'd1, 1'b1);
        follow(8'h33, 3'd1, 1'b1, "R2 len2", 0, 0, 0, 0, 0, 0);
        // R11: reserved code
        @(negedge clk); issue(8'h42, 3'd5, 1'b0);
        follow(8'h42, 3'd5, 1'b0, "R11 reserved", 0, 0, 0, 0, 0, 0);
        // R7: page burst from 0xFE runs past 256 beats, then stopped
        @(negedge clk); issue(8'hFE, 3'd7, 1'b0);
        follow(8'hFE, 3'd7, 1'b0, "R7 page", 1, 261, 0, 0, 0, 0);
        // R8: interleave with page length is sequential
        @(negedge clk); issue(8'h0D, 3'd7, 1'b1);
        follow(8'h0D, 3'd7, 1'b0, "R8 page ilv", 1, 20, 0, 0, 0, 0);
        // R9: early stop of an 8 beat burst
        @(negedge clk); issue(8'h10, 3'd3, 1'b1);
        follow(8'h10, 3'd3, 1'b1, "R9 stop", 1, 2, 0, 0, 0, 0);
        // R9: stop while idle changes nothing
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        check(valid_o === 1'b0 && col_o === 8'd0, "R9 idle stop", int'(valid_o), 0);
        // R10: restart mid burst, then restart with stop high at once
        @(negedge clk); issue(8'h20, 3'd3, 1'b0);
        follow(8'h20, 3'd3, 1'b0, "R10 first", 2, 3, 8'h9A, 3'd2, 1'b1, 1'b0);
        follow(8'h9A, 3'd2, 1'b1, "R10 second", 2, 1, 8'h61, 3'd1, 1'b0, 1'b1);
        follow(8'h61, 3'd1, 1'b0, "R10 start beats stop", 0, 0, 0, 0, 0, 0);

        // constrained random
        pending = 1'b0;
        for (int b = 0; b < 300; b++) begin
            if (!pending) begin
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    stop_i = 1'($urandom_range(0, 1));
                    @(negedge clk);
                    stop_i = 1'b0;
                    check(valid_o === 1'b0, "R9 random idle", int'(valid_o), 0);
                end
                rc    = 8'($urandom);
                case ($urandom_range(0, 5))
                    0: rcode = 3'd0; 1: rcode = 3'd1; 2: rcode = 3'd2;
                    3: rcode = 3'd3; 4: rcode = 3'd7; default: rcode = 3'($urandom_range(4, 6));
                endcase
                ril = 1'($urandom_range(0, 1));
                @(negedge clk); issue(rc, rcode, ril);
            end else begin
                rc = pc; rcode = pcode; ril = pil;
            end
            pending = 1'b0;
            kind = (rcode == 3'd7) ? int'($urandom_range(1, 2)) : int'($urandom_range(0, 2));
            cut  = (rcode == 3'd7) ? int'($urandom_range(0, 299))
                                   : int'($urandom_range(0, exp_len(rcode) - 1));
            pc    = 8'($urandom);
            pcode = ($urandom_range(0, 3) == 0) ? 3'd7 : 3'($urandom_range(0, 3));
            pil   = 1'($urandom_range(0, 1));
            follow(rc, rcode, (rcode == 3'd7) ? 1'b0 : ril, "R4/R5/R7 random", kind, cut,
                   pc, pcode, pil, 1'($urandom_range(0, 1)));
            if (kind == 2) pending = 1'b1;
        end
        if (pending) follow(pc, pcode, (pcode == 3'd7) ? 1'b0 : pil, "R10 tail", 1, 0,
                            0, 0, 0, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule